// File: doc/BRIEF.md
# Multi-Source Reset Supervisor

This block merges three reset causes into one internal reset for a microcontroller subsystem: an active-low external reset pin, a low-supply flag from an analog detector, and a one-cycle overflow pulse from a watchdog counter. Each cause, once qualified, sets a held reset state. A cycle counter keeps the reset asserted for a fixed number of CPU clock cycles after the last cause goes away. The release time therefore scales with the clock frequency. With the default of 400,000 cycles it is 10 ms at 40 MHz and 50 ms at 8 MHz.

The pin and the supply flag are brought into the clock domain through a synchronizer. Each then passes a consecutive-cycle qualifier, so short glitches are discarded. For the supply flag the default window is about 1 µs at 40 MHz. For the pin it is about 1 ms. A software-writable enable bit gates the supply-flag path. The bit comes up set after power-on and is changed only by power-on or by a write. The detector path has no dependence on any low-power state of the CPU.

The reset is produced from a register clocked by the CPU clock. It is driven out in two forms: active-high for the CPU and peripherals, and active-low for a companion programmable-logic module. Power-on reset (`por`) is a synchronous active-high input. It forces the held state, so the stretch interval also follows power-on.

Top module: `sys_reset_sup`

## Requirements
- R1: While `por` is high, `rst_o` is 1 and `lv_en_o` is 1. After the last cycle with `por` high, `rst_o` stays 1 for exactly STRETCH_CYC more cycles and then goes to 0, provided no source is active.
- R2: A one-cycle `wdt_ovf` pulse makes `rst_o` 1 from the next clock edge for exactly STRETCH_CYC cycles.
- R3: `ext_rst_n` is synchronized through SYNC_STAGES flops. A low level lasting fewer than EXT_MIN_CYC cycles never asserts `rst_o`. A level held low longer asserts `rst_o` SYNC_STAGES+EXT_MIN_CYC+1 cycles after the first low cycle.
- R4: `lv_flag` (1 means supply below threshold) is synchronized the same way. With the detector enabled, a high pulse shorter than LV_FILT_CYC cycles never asserts `rst_o`. A level held high longer asserts `rst_o` SYNC_STAGES+LV_FILT_CYC+1 cycles after the first high cycle.
- R5: Reset is released exactly STRETCH_CYC cycles after the last cycle in which any qualified source was active. A new source event during the stretch restarts the count. While a source is active, `rst_o` is 1 on the next cycle.
- R6: A cycle with `lv_en_we` high loads `lv_en_wdata` into `lv_en_o` on the next edge (1 means enabled). While `lv_en_o` is 0, `lv_flag` has no effect on `rst_o`.
- R7: `lv_en_o` changes only on `por` or a write. A reset caused by any source leaves it unchanged.
- R8: `rst_n_o` is always the inverse of `rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| por | input | 1 | Power-on reset, active high, synchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| lv_flag | input | 1 | Low-supply flag from detector, 1 = below threshold, asynchronous |
| wdt_ovf | input | 1 | Watchdog overflow, single-cycle pulse, synchronous |
| lv_en_we | input | 1 | Write strobe for the detector enable bit |
| lv_en_wdata | input | 1 | Value written to the detector enable bit |
| rst_o | output | 1 | Internal reset, active high |
| rst_n_o | output | 1 | Reset to the companion logic module, active low |
| lv_en_o | output | 1 | Current detector enable bit |

## Verification
The bench aims at the exact release cycle after power-on, after a watchdog pulse and after each level source clears. A one-cycle error in the stretch counter or an extra synchronizer stage moves that edge and is reported. Pulses one cycle shorter than each qualifier window must leave the reset low, and pulses just longer must assert it on a known cycle. An off-by-one qualifier either resets on a glitch or asserts late. A second watchdog pulse during the stretch must extend the reset, which catches a counter that is not restarted. The enable bit is cleared and the supply flag raised: a design that does not gate the flag asserts reset. Reading the bit back after a detector reset catches a design that lets its own reset clear the bit.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

    // Qualified reset causes, one bit each
    typedef struct packed {
        logic ext;
        logic lv;
        logic wdt;
    } rst_src_t;

    // Held-reset state of the stretch stage
    typedef enum logic {
        HOLD_OFF = 1'b0,
        HOLD_ON  = 1'b1
    } hold_e;

    function automatic logic src_any(rst_src_t s);
        return s.ext | s.lv | s.wdt;
    endfunction

    // Bits needed for a counter reaching n-1
    function automatic int cnt_w(int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rstsup_sync.sv
module rstsup_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    if (STAGES == 1) begin : g_one
        always_ff @(posedge clk) begin
            if (rst) sr <= '0;
            else     sr <= d;
        end
    end else begin : g_many
        always_ff @(posedge clk) begin
            if (rst) sr <= '0;
            else     sr <= {sr[STAGES-2:0], d};
        end
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/rstsup_filter.sv
module rstsup_filter #(
    parameter int HOLD = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int W = rstsup_pkg::cnt_w(HOLD);
    localparam logic [W-1:0] LAST = W'(HOLD - 1);

    logic [W-1:0] cnt;

    // q rises once d has been high on HOLD consecutive edges; drops at once
    always_ff @(posedge clk) begin
        if (rst || !d) begin
            cnt <= '0;
            q   <= 1'b0;
        end else if (cnt == LAST) begin
            q   <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rstsup_stretch.sv
module rstsup_stretch
    import rstsup_pkg::*;
#(
    parameter int CYC = 16
) (
    input  logic     clk,
    input  logic     por,
    input  rst_src_t src,
    output logic     hold_o
);
    localparam int W = cnt_w(CYC);
    localparam logic [W-1:0] LAST = W'(CYC - 1);

    hold_e          st;
    logic [W-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (por || src_any(src)) begin
            st  <= HOLD_ON;
            cnt <= '0;
        end else if (st == HOLD_ON) begin
            if (cnt == LAST) begin
                st  <= HOLD_OFF;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign hold_o = (st == HOLD_ON);
endmodule

// File: rtl/rstsup_lven.sv
module rstsup_lven (
    input  logic clk,
    input  logic por,
    input  logic we,
    input  logic wdata,
    output logic en_o
);
    // Only power-on and software writes touch the enable bit
    always_ff @(posedge clk) begin
        if (por)     en_o <= 1'b1;
        else if (we) en_o <= wdata;
    end
endmodule

// File: rtl/sys_reset_sup.sv
module sys_reset_sup
    import rstsup_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LV_FILT_CYC = 40,
    parameter int EXT_MIN_CYC = 40000,
    parameter int STRETCH_CYC = 400000
) (
    input  logic clk,
    input  logic por,
    input  logic ext_rst_n,
    input  logic lv_flag,
    input  logic wdt_ovf,
    input  logic lv_en_we,
    input  logic lv_en_wdata,
    output logic rst_o,
    output logic rst_n_o,
    output logic lv_en_o
);
    logic     ext_low_s, lv_s;
    logic     ext_q, lv_q;
    logic     hold;
    logic     src_active;
    rst_src_t src;

    rstsup_sync #(.STAGES(SYNC_STAGES)) u_sync_ext (
        .clk(clk), .rst(por), .d(~ext_rst_n), .q(ext_low_s)
    );
    rstsup_sync #(.STAGES(SYNC_STAGES)) u_sync_lv (
        .clk(clk), .rst(por), .d(lv_flag), .q(lv_s)
    );

    rstsup_filter #(.HOLD(EXT_MIN_CYC)) u_filt_ext (
        .clk(clk), .rst(por), .d(ext_low_s), .q(ext_q)
    );
    rstsup_filter #(.HOLD(LV_FILT_CYC)) u_filt_lv (
        .clk(clk), .rst(por), .d(lv_s), .q(lv_q)
    );

    rstsup_lven u_lven (
        .clk(clk), .por(por), .we(lv_en_we), .wdata(lv_en_wdata), .en_o(lv_en_o)
    );

    always_comb begin
        src.ext = ext_q;
        src.lv  = lv_q & lv_en_o;
        src.wdt = wdt_ovf;
    end

    assign src_active = src_any(src);

    rstsup_stretch #(.CYC(STRETCH_CYC)) u_stretch (
        .clk(clk), .por(por), .src(src), .hold_o(hold)
    );

    assign rst_o   = hold;
    assign rst_n_o = ~hold;
endmodule

// File: rtl/rstsup_checker.sv
module rstsup_checker #(
    parameter int STRETCH_CYC = 16
) (
    input logic clk,
    input logic por,
    input logic wdt_ovf,
    input logic lv_en_we,
    input logic lv_en_wdata,
    input logic rst_o,
    input logic rst_n_o,
    input logic lv_en_o,
    input logic src_active
);
    localparam int QW = $clog2(STRETCH_CYC + 2) + 1;
    localparam logic [QW-1:0] TARGET = QW'(STRETCH_CYC);

    // Cycles since power-on or the last active source, saturating
    logic [QW-1:0] quiet;
    always_ff @(posedge clk) begin
        if (por || src_active) quiet <= '0;
        else if (quiet != '1)  quiet <= quiet + 1'b1;
    end

    p_release_time_r1: assert property (@(posedge clk) disable iff (por)
        $fell(rst_o) |-> quiet == TARGET);

    p_wdt_asserts_r2: assert property (@(posedge clk) disable iff (por)
        wdt_ovf |=> rst_o);

    p_src_holds_r5: assert property (@(posedge clk) disable iff (por)
        src_active |=> rst_o);

    p_en_write_r6: assert property (@(posedge clk) disable iff (por)
        lv_en_we |=> lv_en_o == $past(lv_en_wdata));

    p_en_stable_r7: assert property (@(posedge clk) disable iff (por)
        !lv_en_we |=> $stable(lv_en_o));

    p_pair_r8: assert property (@(posedge clk) disable iff (por)
        rst_n_o != rst_o);
endmodule

bind sys_reset_sup rstsup_checker #(.STRETCH_CYC(STRETCH_CYC)) u_chk (
    .clk(clk), .por(por), .wdt_ovf(wdt_ovf), .lv_en_we(lv_en_we),
    .lv_en_wdata(lv_en_wdata), .rst_o(rst_o), .rst_n_o(rst_n_o),
    .lv_en_o(lv_en_o), .src_active(src_active)
);

// File: tb/sys_reset_sup_test.sv
`timescale 1ns/1ps
module sys_reset_sup_test;
    localparam int SS = 2;
    localparam int LF = 6;
    localparam int EM = 10;
    localparam int S  = 40;

    localparam int SIG_RST  = 0;
    localparam int SIG_RSTN = 1;
    localparam int SIG_EN   = 2;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic ext_rst_n = 1'b1;
    logic lv_flag = 1'b0;
    logic wdt_ovf = 1'b0;
    logic lv_en_we = 1'b0;
    logic lv_en_wdata = 1'b0;
    logic rst_o, rst_n_o, lv_en_o;

    int unsigned cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int unsigned at;
        int          sig;
        logic        val;
        string       tag;
    } exp_t;
    exp_t sb[$];

    sys_reset_sup #(
        .SYNC_STAGES(SS), .LV_FILT_CYC(LF), .EXT_MIN_CYC(EM), .STRETCH_CYC(S)
    ) uut (
        .clk(clk), .por(por), .ext_rst_n(ext_rst_n), .lv_flag(lv_flag),
        .wdt_ovf(wdt_ovf), .lv_en_we(lv_en_we), .lv_en_wdata(lv_en_wdata),
        .rst_o(rst_o), .rst_n_o(rst_n_o), .lv_en_o(lv_en_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic pick(int sig);
        if (sig == SIG_RST)  return rst_o;
        if (sig == SIG_RSTN) return rst_n_o;
        return lv_en_o;
    endfunction

    // Monitor: compare queued expectations at mid-cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            logic act;
            e = sb.pop_front();
            act = pick(e.sig);
            checks++;
            if (e.at != cyc || act !== e.val) begin
                errors++;
                $display("FAIL %s sig%0d cycle %0d (due %0d): actual %b expected %b",
                         e.tag, e.sig, cyc, e.at, act, e.val);
            end
        end
    end

    task automatic expect_at(int off, int sig, logic val, string tag);
        sb.push_back('{cyc + off, sig, val, tag});
    endtask

    task automatic expect_span(int first, int last, int sig, logic val, string tag);
        for (int i = first; i <= last; i++) sb.push_back('{cyc + i, sig, val, tag});
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        tick(3);
        // R1 reset state and R6 default enable
        expect_at(1, SIG_EN, 1'b1, "R6 default");
        expect_at(1, SIG_RST, 1'b1, "R1 por");
        expect_at(S - 1, SIG_RST, 1'b1, "R1 stretch");
        expect_at(S, SIG_RST, 1'b0, "R1 release");
        expect_at(S, SIG_RSTN, 1'b1, "R8 release");
        por = 1'b0;
        tick(S + 5);

        // R2 watchdog pulse
        wdt_ovf = 1'b1;
        expect_at(1, SIG_RST, 1'b1, "R2 assert");
        expect_at(1, SIG_RSTN, 1'b0, "R8 assert");
        expect_at(S, SIG_RST, 1'b1, "R2 hold");
        expect_at(S + 1, SIG_RST, 1'b0, "R2 release");
        tick(1);
        wdt_ovf = 1'b0;
        tick(S + 6);

        // R5 retrigger during stretch
        wdt_ovf = 1'b1;
        expect_at(1, SIG_RST, 1'b1, "R5 first");
        tick(1);
        wdt_ovf = 1'b0;
        tick(9);
        wdt_ovf = 1'b1;
        expect_at(S - 9, SIG_RST, 1'b1, "R5 extended");
        expect_at(S, SIG_RST, 1'b1, "R5 hold");
        expect_at(S + 1, SIG_RST, 1'b0, "R5 release");
        tick(1);
        wdt_ovf = 1'b0;
        tick(S + 6);

        // R4 short supply glitch ignored
        lv_flag = 1'b1;
        expect_span(1, LF + 10, SIG_RST, 1'b0, "R4 glitch");
        tick(LF - 1);
        lv_flag = 1'b0;
        tick(LF + 12);

        // R4 long low-supply level, R5 release, R7 enable kept
        lv_flag = 1'b1;
        expect_at(SS + LF, SIG_RST, 1'b0, "R4 before");
        expect_at(SS + LF + 1, SIG_RST, 1'b1, "R4 assert");
        tick(LF + 20);
        lv_flag = 1'b0;
        expect_at(S + 2, SIG_RST, 1'b1, "R5 lv hold");
        expect_at(S + 3, SIG_RST, 1'b0, "R5 lv release");
        expect_at(S + 3, SIG_EN, 1'b1, "R7 enable kept");
        tick(S + 6);

        // R3 short pin glitch ignored
        ext_rst_n = 1'b0;
        expect_span(1, EM + 10, SIG_RST, 1'b0, "R3 glitch");
        tick(EM - 1);
        ext_rst_n = 1'b1;
        tick(EM + 12);

        // R3 long pin low, R5 release
        ext_rst_n = 1'b0;
        expect_at(SS + EM, SIG_RST, 1'b0, "R3 before");
        expect_at(SS + EM + 1, SIG_RST, 1'b1, "R3 assert");
        tick(EM + 20);
        ext_rst_n = 1'b1;
        expect_at(S + 2, SIG_RST, 1'b1, "R5 ext hold");
        expect_at(S + 3, SIG_RST, 1'b0, "R5 ext release");
        tick(S + 6);

        // R6 disable the detector, then the flag has no effect
        lv_en_we = 1'b1;
        lv_en_wdata = 1'b0;
        expect_at(1, SIG_EN, 1'b0, "R6 write 0");
        tick(1);
        lv_en_we = 1'b0;
        tick(2);
        lv_flag = 1'b1;
        expect_span(1, LF + 20, SIG_RST, 1'b0, "R6 gated");
        expect_at(LF + 20, SIG_EN, 1'b0, "R6 still off");
        tick(LF + 20);
        lv_flag = 1'b0;
        tick(10);
        lv_en_we = 1'b1;
        lv_en_wdata = 1'b1;
        expect_at(1, SIG_EN, 1'b1, "R6 write 1");
        expect_at(2, SIG_RST, 1'b0, "R6 no stale");
        tick(1);
        lv_en_we = 1'b0;
        tick(5);

        // R7 watchdog reset leaves enable alone
        wdt_ovf = 1'b1;
        expect_at(1, SIG_RST, 1'b1, "R7 wdt");
        expect_at(2, SIG_EN, 1'b1, "R7 enable kept");
        tick(1);
        wdt_ovf = 1'b0;
        tick(S + 10);

        while (sb.size() > 0) tick(1);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule